// File: doc/BRIEF.md
# Byte-Aligned Double-Buffered Scan Shifter

This block turns bytes written from a processor bus into a serial scan output stream. It holds up to two bytes in a pair of byte buffers. It sends them out one bit per enabled test-clock cycle, least significant bit first. The block owns no bit counter. The bit position comes from a 3-bit phase count that is shared by every shifter in the scan controller. That shared count keeps all channels byte-aligned.

The phase count is an input. When it wraps from 7 back to 0 during a shift cycle, the active byte is released and the next loaded byte takes its place. Because of this, a loaded shifter that is enabled at a nonzero phase starts mid-byte. For example, enabling it at phase 3 sends only bits 3 to 7 of its first byte. The not-full flag tells the bus side that at least one buffer can take a byte. A write that arrives while both buffers hold data is dropped.

Top module: `dbs_shifter`

## Requirements
- R1: While the synchronous active-high reset is asserted, both buffers are emptied. One clock after reset is sampled, `not_full` is 1 and `sdo` is 0.
- R2: `not_full` is 1 whenever fewer than two bytes are held. It is 0 when both buffers hold a byte.
- R3: A write is accepted only if `not_full` was 1 before the clock edge. A write while both buffers are full is dropped, even in the same cycle as a release, and the dropped byte never appears on `sdo`.
- R4: A shift cycle is a clock edge with `tck_en`=1, `shift_en`=1 and at least one byte held. On a shift cycle, `sdo` takes bit number `phase_cnt` of the active byte, registered, so it is visible after that edge. With `phase_cnt` stepping 0..7, the bits leave least significant first.
- R5: On a shift cycle with `phase_cnt`=7, the active byte is released. The next held byte becomes active, and bytes go out in the order they were written.
- R6: A loaded shifter first enabled at phase 3 sends only bits 3..7 of its first byte (five bits). The following byte is then sent in full from phase 0.
- R7: On any cycle that is not a shift cycle because `tck_en` or `shift_en` is 0, `sdo` holds its value. The active byte is not consumed, even if `phase_cnt` passes 7.
- R8: With no byte held, enabled test-clock cycles leave `sdo` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Bus write strobe for the byte buffers |
| wr_data | input | 8 | Byte to load |
| shift_en | input | 1 | Mode bit that enables shifting for this channel |
| phase_cnt | input | 3 | Shared bit-phase count from the test-clock control |
| tck_en | input | 1 | Test-clock cycle enable |
| sdo | output | 1 | Serial scan data out (registered) |
| not_full | output | 1 | At least one buffer is free |

## Verification
The bench targets the partial first byte at phase 3. A design that kept a private bit counter would send all eight bits there and would fall out of alignment with the next byte. It also writes while both buffers are full, including on the very edge that releases a byte. A design that accepted that write would later shift out a byte that should have been lost. Shift cycles with the enable low across a phase wrap would show a design that releases bytes without shifting, because later bits would come out of the wrong byte. Enabled cycles on an empty shifter, and a reset during a full state, would expose stray toggling of `sdo` and stale data that should have been flushed.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    // Action taken by the channel on the current clock edge
    typedef enum logic [1:0] {
        STEP_IDLE  = 2'd0,
        STEP_SHIFT = 2'd1,
        STEP_WRAP  = 2'd2
    } step_e;

    // Per-cycle shift control produced by the sequencer
    typedef struct packed {
        step_e step;
        logic  bit_val;
    } shift_ctl_t;

    // True when the phase is the last bit slot of a byte
    function automatic logic is_last_phase(input int unsigned ph, input int unsigned ph_w);
        return ph == ((1 << ph_w) - 1);
    endfunction

endpackage

// File: rtl/dbs_buffer_pair.sv
module dbs_buffer_pair #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_BUF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              release_i,
    output logic [DATA_W-1:0] head_data,
    output logic              head_valid,
    output logic              not_full
);

    localparam int unsigned PTR_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_BUF - 1);

    logic [DATA_W-1:0] mem_q [NUM_BUF];
    logic              vld_q [NUM_BUF];
    logic [NUM_BUF-1:0] vld_vec;
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic              accept;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        for (int k = 0; k < NUM_BUF; k++) begin
            vld_vec[k] = vld_q[k];
        end
    end

    assign not_full   = ~&vld_vec;
    assign accept     = wr_en && not_full;
    assign head_data  = mem_q[rd_ptr_q];
    assign head_valid = vld_q[rd_ptr_q];

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
                mem_q[i] <= '0;
            end else begin
                if (release_i && rd_ptr_q == PTR_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
                if (accept && wr_ptr_q == PTR_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    mem_q[i] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (accept)    wr_ptr_q <= step_ptr(wr_ptr_q);
            if (release_i) rd_ptr_q <= step_ptr(rd_ptr_q);
        end
    end

    // A release must only happen while the active slot holds a byte
    assert_release_has_data_R5: assert property (@(posedge clk) disable iff (rst)
        release_i |-> head_valid);

    // A write into a full pair leaves the pair full and the active byte untouched
    assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !not_full && !release_i) |=> (!not_full && $stable(head_data)));

endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PH_W   = $clog2(DATA_W)
) (
    input  logic              tck_en,
    input  logic              shift_en,
    input  logic [PH_W-1:0]   phase,
    input  logic              head_valid,
    input  logic [DATA_W-1:0] head_data,
    output shift_ctl_t        ctl
);

    logic fire;

    assign fire = tck_en && shift_en && head_valid;

    always_comb begin
        ctl.bit_val = head_data[phase];
        if (!fire) begin
            ctl.step = STEP_IDLE;
        end else if (is_last_phase(int'(phase), PH_W)) begin
            ctl.step = STEP_WRAP;
        end else begin
            ctl.step = STEP_SHIFT;
        end
    end

endmodule

// File: rtl/dbs_shifter.sv
module dbs_shifter
    import dbs_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_BUF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shift_en,
    input  logic [$clog2(DATA_W)-1:0] phase_cnt,
    input  logic              tck_en,
    output logic              sdo,
    output logic              not_full
);

    localparam int unsigned PH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] head_data;
    logic              head_valid;
    logic              release_w;
    shift_ctl_t        ctl;

    dbs_buffer_pair #(
        .DATA_W  (DATA_W),
        .NUM_BUF (NUM_BUF)
    ) u_bufs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .release_i  (release_w),
        .head_data  (head_data),
        .head_valid (head_valid),
        .not_full   (not_full)
    );

    dbs_seq #(
        .DATA_W (DATA_W),
        .PH_W   (PH_W)
    ) u_seq (
        .tck_en     (tck_en),
        .shift_en   (shift_en),
        .phase      (phase_cnt),
        .head_valid (head_valid),
        .head_data  (head_data),
        .ctl        (ctl)
    );

    assign release_w = (ctl.step == STEP_WRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo <= 1'b0;
        end else if (ctl.step != STEP_IDLE) begin
            sdo <= ctl.bit_val;
        end
    end

    // Reset leaves the pair empty and the serial line low
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (not_full && !sdo));

    // Without both enables the serial output is frozen
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(tck_en && shift_en) |=> $stable(sdo));

    // Releasing a byte with no competing write frees a buffer
    assert_free_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        (release_w && !wr_en) |=> not_full);

endmodule

// File: tb/dbs_shifter_tb_top.sv
module dbs_shifter_tb_top;

    localparam time CLK_P = 8ns;

    typedef struct {
        bit    sdo;
        bit    nf;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       shift_en = 1'b0;
    logic [2:0] phase_cnt = '0;
    logic       tck_en = 1'b0;
    logic       sdo;
    logic       not_full;

    int total = 0;
    int bad = 0;
    bit done = 0;

    exp_t       exp_q[$];
    logic [7:0] model_q[$];
    bit         last_sdo = 0;
    logic [2:0] ph = '0;

    always #(CLK_P / 2) clk = ~clk;

    dbs_shifter dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .shift_en  (shift_en),
        .phase_cnt (phase_cnt),
        .tck_en    (tck_en),
        .sdo       (sdo),
        .not_full  (not_full)
    );

    task automatic note(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: compares each registered result one step after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            note(sdo === e.sdo, e.tag, int'(sdo), int'(e.sdo));
            note(not_full === e.nf, "R2", int'(not_full), int'(e.nf));
        end
    end

    // Driver: applies one cycle of stimulus and queues the expected result
    task automatic cyc(input bit w, input logic [7:0] d, input bit t, input bit e, input string tag);
        int  pre_sz;
        bit  fire;
        exp_t x;
        @(negedge clk);
        wr_en = w; wr_data = d; tck_en = t; shift_en = e; phase_cnt = ph;
        pre_sz = model_q.size();
        fire = t && e && (pre_sz > 0);
        if (fire) begin
            last_sdo = model_q[0][ph];
            if (ph == 3'd7) void'(model_q.pop_front());
        end
        if (w && pre_sz < 2) model_q.push_back(d);
        x.sdo = last_sdo;
        x.nf  = (model_q.size() < 2);
        x.tag = tag;
        exp_q.push_back(x);
        if (t) ph = ph + 3'd1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 0; tck_en = 0; shift_en = 0;
        @(negedge clk);
        @(negedge clk);
        note(not_full === 1'b1, "R1", int'(not_full), 1);
        note(sdo === 1'b0, "R1", int'(sdo), 0);
        rst = 1'b0;
        model_q.delete();
        last_sdo = 0;
        ph = '0;
        phase_cnt = '0;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();

        // R4: single byte, phases 0..7, LSB first
        cyc(1, 8'hA5, 0, 0, "R4");
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1, 1, "R4");
        cyc(0, 8'h00, 0, 0, "R4");

        // R2 and R3: fill both buffers, then a write while full is dropped
        cyc(1, 8'h3C, 0, 0, "R2");
        cyc(1, 8'h81, 0, 0, "R2");
        cyc(1, 8'hFF, 0, 0, "R3");
        // R5: two bytes leave in write order
        for (int i = 0; i < 16; i++) cyc(0, 8'h00, 1, 1, "R5");
        cyc(0, 8'h00, 0, 0, "R5");

        // R3: write on the same edge as a release, while full, is dropped
        cyc(1, 8'h5A, 0, 0, "R3");
        cyc(1, 8'hC3, 0, 0, "R3");
        for (int i = 0; i < 7; i++) cyc(0, 8'h00, 1, 1, "R3");
        cyc(1, 8'hEE, 1, 1, "R3");
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1, 1, "R3");
        cyc(0, 8'h00, 0, 0, "R3");

        // R7: byte held, shift_en low across a phase wrap, then tck_en low
        cyc(1, 8'h96, 0, 0, "R7");
        for (int i = 0; i < 10; i++) cyc(0, 8'h00, 1, 0, "R7");
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 0, 1, "R7");
        for (int i = 0; i < 6; i++) cyc(0, 8'h00, 1, 1, "R7");
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1, 1, "R7");
        cyc(0, 8'h00, 0, 0, "R7");

        // R6: enable a loaded shifter at phase 3; R8 while empty to get there
        do_reset();
        cyc(1, 8'hFF, 0, 0, "R8");
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1, 1, "R8");
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 1, 1, "R8");
        cyc(1, 8'hB6, 0, 0, "R6");
        cyc(1, 8'h4D, 0, 0, "R6");
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 1, 1, "R6");
        note(model_q.size() == 1, "R6", model_q.size(), 1);
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1, 1, "R6");
        cyc(0, 8'h00, 0, 0, "R6");

        // R1: reset while full flushes the buffers
        cyc(1, 8'h0F, 0, 0, "R1");
        cyc(1, 8'hF0, 0, 0, "R1");
        cyc(0, 8'h00, 0, 0, "R1");
        do_reset();
        for (int i = 0; i < 8; i++) cyc(0, 8'h00, 1, 1, "R8");
        cyc(0, 8'h00, 0, 0, "R8");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule